// File: doc/BRIEF.md
# Slotframe Timeslot Scheduler

This block tracks where a network node stands in a repeating time-slotted schedule. A sub-slot counter advances on a periodic reference tick enable (nominally 1 MHz, so a 10 ms timeslot spans 10000 ticks). Each time the sub-slot count finishes, the timeslot index within the current group advances. The schedule holds 50 timeslots per group. When a group completes, the group index advances, and it runs through 120 groups per slotframe. One full slotframe is therefore 6000 timeslots, which lasts one minute.

For the current timeslot the block decodes a 2-bit slot kind from the slot's position inside its group: beacon advertisement, control, management or shared. It emits a one-cycle pulse when a new timeslot begins, and another when a new group begins. An external time synchroniser can realign the node at any time with a synchronous load of the slot and group indices. The load also restarts the sub-slot count, so the node's next slot boundary falls one full slot period later.

Top module: `tsch_slot_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the slot and group indices become 0 and both start pulses become 0. The slot kind then reads 00.
- R2: With no load pending, the slot index advances by one on the clock edge that accepts the TICKS_PER_SLOT-th `tick_en` since the slot began. Cycles with `tick_en` low change neither index.
- R3: `slot_start` is high for exactly the one cycle in which a newly advanced slot index is first presented.
- R4: The slot index counts 0 to SLOTS_PER_GROUP-1 and then returns to 0. On that return the group index increments and `group_start` is high for the same single cycle as `slot_start`.
- R5: The group index counts 0 to GROUPS_PER_FRAME-1 and then returns to 0.
- R6: `slot_kind` encodes slot index 0 as 00 (advertisement) and slot index SHARED_SLOT (24) as 11 (shared). Any other odd index is 01 (control), and any other even index is 10 (management).
- R7: A valid `load_en` sets the slot and group indices to `load_slot` and `load_group` on the next clock edge and clears the sub-slot count. No start pulse is produced by the load itself. The next `slot_start` comes TICKS_PER_SLOT tick enables later.
- R8: When a valid load coincides with a slot boundary, the load wins: the loaded values appear and neither start pulse is raised in that cycle.
- R9: A load whose slot value exceeds SLOTS_PER_GROUP-1 or whose group value exceeds GROUPS_PER_FRAME-1 is ignored. Counting, including the sub-slot count, continues as if `load_en` were low.
- R10: Over one slotframe, the slots started comprise exactly 120 advertisement, 3000 control, 2760 management and 120 shared slots, with 120 group starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Reference tick enable, one cycle per tick |
| load_en | input | 1 | Synchronous realignment request |
| load_slot | input | 6 | Slot index to load |
| load_group | input | 7 | Group index to load |
| slot_idx | output | 6 | Current timeslot index within the group |
| group_idx | output | 7 | Current group index within the slotframe |
| slot_kind | output | 2 | Kind of the current timeslot (see R6) |
| slot_start | output | 1 | One-cycle pulse at the start of a timeslot |
| group_start | output | 1 | One-cycle pulse at the start of a group |

## Verification
A realignment load and a slot boundary can land on the same clock edge, and this is the collision that matters. The bench arranges it by loading a slot and letting exactly TICKS_PER_SLOT-1 ticks pass. It then asserts a valid load together with the final tick. The result is judged by checking three things: the loaded indices appear, no start pulse is raised, and the following pulse arrives a full slot later. An out-of-range load is also placed on a tick cycle to show that it leaves the sub-slot count running, so the boundary that follows arrives on time.

// File: rtl/tsch_slot_pkg.sv
// Shared definitions for the slotframe timeslot scheduler.
// Assumes: slot kinds fit a 2-bit code that consumers decode directly.
package tsch_slot_pkg;

    typedef enum logic [1:0] {
        KIND_ADV    = 2'b00,
        KIND_CTRL   = 2'b01,
        KIND_MGMT   = 2'b10,
        KIND_SHARED = 2'b11
    } slot_kind_e;

endpackage

// File: rtl/tsch_mod_counter.sv
// Modulo-MOD counter with a synchronous load.
// Counts 0..MOD-1 on each step and wraps to 0. Load has priority over step.
// Assumes: the caller only presents load values below MOD.
module tsch_mod_counter #(
    parameter int MOD = 50,
    parameter int W   = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] LAST_V = W'(MOD - 1);

    logic [W-1:0] cnt_q;

    // Count state: reset, load, or step with wrap at MOD-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            if (cnt_q == LAST_V) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    assign value = cnt_q;

endmodule

// File: rtl/tsch_slot_classifier.sv
// Decodes the slot kind from a slot index within a group.
// Index 0 is advertisement, SHARED_IDX is shared, other odd indices are
// control and other even indices are management.
// Assumes: SHARED_IDX is even and nonzero, so the odd rule never overlaps it.
module tsch_slot_classifier
    import tsch_slot_pkg::*;
#(
    parameter int SLOTS      = 50,
    parameter int SHARED_IDX = 24,
    parameter int W          = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [W-1:0] slot_idx,
    output logic [1:0]   kind
);

    localparam logic [W-1:0] SHARED_V = W'(SHARED_IDX);

    slot_kind_e kind_e;

    // Priority decode of position to kind.
    always_comb begin
        if (slot_idx == '0) begin
            kind_e = KIND_ADV;
        end else if (slot_idx == SHARED_V) begin
            kind_e = KIND_SHARED;
        end else if (slot_idx[0]) begin
            kind_e = KIND_CTRL;
        end else begin
            kind_e = KIND_MGMT;
        end
    end

    assign kind = kind_e;

endmodule

// File: rtl/tsch_slot_timer.sv
// Slotframe timeslot scheduler top.
// Chains a sub-slot tick counter, a slot-in-group counter and a
// group-in-frame counter, decodes the slot kind and raises start pulses.
// A valid load realigns slot and group, clears the tick count and
// suppresses the pulses for that cycle. Out-of-range loads are ignored.
// Assumes: tick_en is a single-cycle enable synchronous to clk.
module tsch_slot_timer #(
    parameter int TICKS_PER_SLOT   = 10000,
    parameter int SLOTS_PER_GROUP  = 50,
    parameter int GROUPS_PER_FRAME = 120,
    parameter int SHARED_SLOT      = 24,
    localparam int TICK_W  = (TICKS_PER_SLOT > 1)   ? $clog2(TICKS_PER_SLOT)   : 1,
    localparam int SLOT_W  = (SLOTS_PER_GROUP > 1)  ? $clog2(SLOTS_PER_GROUP)  : 1,
    localparam int GROUP_W = (GROUPS_PER_FRAME > 1) ? $clog2(GROUPS_PER_FRAME) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               load_en,
    input  logic [SLOT_W-1:0]  load_slot,
    input  logic [GROUP_W-1:0] load_group,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic [GROUP_W-1:0] group_idx,
    output logic [1:0]         slot_kind,
    output logic               slot_start,
    output logic               group_start
);

    localparam logic [TICK_W-1:0]  TICK_LAST  = TICK_W'(TICKS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0]  SLOT_LAST  = SLOT_W'(SLOTS_PER_GROUP - 1);
    localparam logic [GROUP_W-1:0] GROUP_LAST = GROUP_W'(GROUPS_PER_FRAME - 1);

    logic [TICK_W-1:0]  tick_cnt;
    logic [SLOT_W-1:0]  slot_cnt;
    logic [GROUP_W-1:0] group_cnt;
    logic               load_ok;
    logic               tick_wrap;
    logic               slot_wrap;
    logic               slot_start_q;
    logic               group_start_q;

    // Accept a load only when both indices are in range.
    always_comb begin
        load_ok = load_en && (load_slot <= SLOT_LAST) && (load_group <= GROUP_LAST);
    end

    // Boundary detection along the counter chain.
    always_comb begin
        tick_wrap = tick_en && (tick_cnt == TICK_LAST);
        slot_wrap = tick_wrap && (slot_cnt == SLOT_LAST);
    end

    tsch_mod_counter #(.MOD(TICKS_PER_SLOT), .W(TICK_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick_en),
        .load     (load_ok),
        .load_val ('0),
        .value    (tick_cnt)
    );

    tsch_mod_counter #(.MOD(SLOTS_PER_GROUP), .W(SLOT_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick_wrap),
        .load     (load_ok),
        .load_val (load_slot),
        .value    (slot_cnt)
    );

    tsch_mod_counter #(.MOD(GROUPS_PER_FRAME), .W(GROUP_W)) u_group (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (slot_wrap),
        .load     (load_ok),
        .load_val (load_group),
        .value    (group_cnt)
    );

    tsch_slot_classifier #(
        .SLOTS      (SLOTS_PER_GROUP),
        .SHARED_IDX (SHARED_SLOT),
        .W          (SLOT_W)
    ) u_kind (
        .slot_idx (slot_cnt),
        .kind     (slot_kind)
    );

    // Start pulses accompany the advanced indices; a load suppresses them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_start_q  <= 1'b0;
            group_start_q <= 1'b0;
        end else begin
            slot_start_q  <= tick_wrap && !load_ok;
            group_start_q <= slot_wrap && !load_ok;
        end
    end

    assign slot_idx    = slot_cnt;
    assign group_idx   = group_cnt;
    assign slot_start  = slot_start_q;
    assign group_start = group_start_q;

endmodule

// File: rtl/tsch_slot_timer_chk.sv
// Property checker for the slotframe timeslot scheduler, bound to the top.
// Observes ports only.
module tsch_slot_timer_chk #(
    parameter int TICKS_PER_SLOT   = 10000,
    parameter int SLOTS_PER_GROUP  = 50,
    parameter int GROUPS_PER_FRAME = 120,
    parameter int SHARED_SLOT      = 24,
    parameter int SLOT_W           = 6,
    parameter int GROUP_W          = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               load_en,
    input logic [SLOT_W-1:0]  load_slot,
    input logic [GROUP_W-1:0] load_group,
    input logic [SLOT_W-1:0]  slot_idx,
    input logic [GROUP_W-1:0] group_idx,
    input logic [1:0]         slot_kind,
    input logic               slot_start,
    input logic               group_start
);

    localparam logic [SLOT_W-1:0]  SLOT_LAST  = SLOT_W'(SLOTS_PER_GROUP - 1);
    localparam logic [GROUP_W-1:0] GROUP_LAST = GROUP_W'(GROUPS_PER_FRAME - 1);
    localparam logic [SLOT_W-1:0]  SHARED_V   = SLOT_W'(SHARED_SLOT);

    logic load_valid;
    assign load_valid = load_en && (load_slot <= SLOT_LAST) && (load_group <= GROUP_LAST);

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= SLOT_LAST); // R4

    AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        group_idx <= GROUP_LAST); // R5

    AST_KIND_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == '0) |-> (slot_kind == 2'b00)); // R6

    AST_KIND_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == SHARED_V) |-> (slot_kind == 2'b11)); // R6

    AST_GROUP_WITH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        group_start |-> (slot_start && slot_idx == '0)); // R4

    AST_START_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && $past(rst_n)) |->
            (slot_idx == (($past(slot_idx) == SLOT_LAST) ? '0 : $past(slot_idx) + SLOT_W'(1)))); // R3

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_en) |=> ($stable(slot_idx) && $stable(group_idx) && !slot_start)); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> (slot_idx == $past(load_slot) && group_idx == $past(load_group)
                        && !slot_start && !group_start)); // R7

    AST_BAD_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !load_valid && !tick_en) |=> ($stable(slot_idx) && $stable(group_idx))); // R9

    generate
        if (TICKS_PER_SLOT > 1) begin : g_pulse_width
            AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                slot_start |=> !slot_start); // R3
        end
    endgenerate

endmodule

bind tsch_slot_timer tsch_slot_timer_chk #(
    .TICKS_PER_SLOT   (TICKS_PER_SLOT),
    .SLOTS_PER_GROUP  (SLOTS_PER_GROUP),
    .GROUPS_PER_FRAME (GROUPS_PER_FRAME),
    .SHARED_SLOT      (SHARED_SLOT),
    .SLOT_W           (SLOT_W),
    .GROUP_W          (GROUP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .load_en     (load_en),
    .load_slot   (load_slot),
    .load_group  (load_group),
    .slot_idx    (slot_idx),
    .group_idx   (group_idx),
    .slot_kind   (slot_kind),
    .slot_start  (slot_start),
    .group_start (group_start)
);

// File: tb/sim_tsch_slot_timer.sv
// Self-checking bench for the slotframe timeslot scheduler.
module sim_tsch_slot_timer;

    localparam int T = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       load_en = 1'b0;
    logic [5:0] load_slot = '0;
    logic [6:0] load_group = '0;
    logic [5:0] slot_idx;
    logic [6:0] group_idx;
    logic [1:0] slot_kind;
    logic       slot_start;
    logic       group_start;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tsch_slot_timer #(.TICKS_PER_SLOT(T)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
        .load_slot(load_slot), .load_group(load_group), .slot_idx(slot_idx),
        .group_idx(group_idx), .slot_kind(slot_kind), .slot_start(slot_start),
        .group_start(group_start)
    );

    localparam int NV = 8;
    localparam int VEC_SLOT  [NV] = '{0, 1, 2, 23, 24, 25, 48, 49};
    localparam int VEC_GROUP [NV] = '{0, 119, 5, 60, 7, 1, 118, 33};
    localparam int VEC_KIND  [NV] = '{0, 1, 2, 1, 3, 1, 2, 1};

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(int s, int g);
        load_en = 1'b1;
        load_slot = 6'(s);
        load_group = 7'(g);
        @(negedge clk);
        load_en = 1'b0;
    endtask

    initial begin
        int n_adv, n_ctl, n_mgt, n_sh, n_grp;
        @(negedge clk);
        tick_en = 1'b1;
        cyc(3);
        check("R1 slot", int'(slot_idx), 0);
        check("R1 group", int'(group_idx), 0);
        check("R1 kind", int'(slot_kind), 0);
        check("R1 pulses", int'({slot_start, group_start}), 0);
        rst_n = 1'b1;
        tick_en = 1'b0;

        // Table: load a position, check indices, kind and absence of pulse (R6, R7)
        for (int i = 0; i < NV; i++) begin
            do_load(VEC_SLOT[i], VEC_GROUP[i]);
            check("R7 slot", int'(slot_idx), VEC_SLOT[i]);
            check("R7 group", int'(group_idx), VEC_GROUP[i]);
            check("R6 kind", int'(slot_kind), VEC_KIND[i]);
            check("R7 no pulse", int'(slot_start), 0);
        end

        // R2: tick_en low holds everything
        do_load(5, 3);
        cyc(10);
        check("R2 hold slot", int'(slot_idx), 5);
        check("R2 hold pulse", int'(slot_start), 0);

        // R2/R3: advance after T ticks, pulse for one cycle
        tick_en = 1'b1;
        cyc(T - 1);
        check("R2 not yet", int'(slot_idx), 5);
        check("R3 no early pulse", int'(slot_start), 0);
        cyc(1);
        check("R2 advanced", int'(slot_idx), 6);
        check("R3 pulse", int'(slot_start), 1);
        check("R6 mgmt after advance", int'(slot_kind), 2);
        cyc(1);
        check("R3 pulse width", int'(slot_start), 0);

        // R4: slot wrap increments group with group_start
        tick_en = 1'b0;
        do_load(49, 7);
        tick_en = 1'b1;
        cyc(T);
        check("R4 slot wrap", int'(slot_idx), 0);
        check("R4 group inc", int'(group_idx), 8);
        check("R4 group_start", int'(group_start), 1);
        check("R4 slot_start", int'(slot_start), 1);
        cyc(1);
        check("R4 group_start width", int'(group_start), 0);

        // R5: group wrap
        tick_en = 1'b0;
        do_load(49, 119);
        tick_en = 1'b1;
        cyc(T);
        check("R5 group wrap", int'(group_idx), 0);
        check("R5 slot wrap", int'(slot_idx), 0);

        // R8: load coincides with a slot boundary
        tick_en = 1'b0;
        do_load(49, 5);
        tick_en = 1'b1;
        cyc(T - 1);
        do_load(10, 7);
        check("R8 slot loaded", int'(slot_idx), 10);
        check("R8 group loaded", int'(group_idx), 7);
        check("R8 no slot_start", int'(slot_start), 0);
        check("R8 no group_start", int'(group_start), 0);
        cyc(T - 1);
        check("R8 next not early", int'(slot_idx), 10);
        cyc(1);
        check("R8 next slot", int'(slot_idx), 11);
        check("R8 next pulse", int'(slot_start), 1);

        // R9: out-of-range loads ignored, tick count keeps running
        tick_en = 1'b0;
        do_load(7, 2);
        tick_en = 1'b1;
        cyc(T - 2);
        do_load(60, 2);
        check("R9 bad slot ignored", int'(slot_idx), 7);
        check("R9 no pulse", int'(slot_start), 0);
        cyc(1);
        check("R9 boundary on time", int'(slot_idx), 8);
        check("R9 pulse on time", int'(slot_start), 1);
        tick_en = 1'b0;
        do_load(3, 125);
        check("R9 bad group ignored slot", int'(slot_idx), 8);
        check("R9 bad group ignored group", int'(group_idx), 2);

        // R10: per-type totals over a whole slotframe
        do_load(0, 0);
        tick_en = 1'b1;
        n_adv = 0; n_ctl = 0; n_mgt = 0; n_sh = 0; n_grp = 0;
        for (int c = 0; c < 6000 * T; c++) begin
            @(negedge clk);
            if (slot_start) begin
                case (slot_kind)
                    2'b00: n_adv++;
                    2'b01: n_ctl++;
                    2'b10: n_mgt++;
                    default: n_sh++;
                endcase
            end
            if (group_start) n_grp++;
        end
        check("R10 adv", n_adv, 120);
        check("R10 ctrl", n_ctl, 3000);
        check("R10 mgmt", n_mgt, 2760);
        check("R10 shared", n_sh, 120);
        check("R10 groups", n_grp, 120);
        check("R10 end slot", int'(slot_idx), 0);
        check("R10 end group", int'(group_idx), 0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule